// File: doc/BRIEF.md
# Threshold FIFO with DMA Requests

This block is a 32-word by 16-bit first-in first-out buffer placed between a processor register port and a card data engine. The transfer direction decides who fills it and who drains it. When receiving, the engine pushes and the processor pops. When transmitting, the processor pushes and the engine pops. Strobes from the side that does not own an operation in the current direction have no effect.

Two programmable levels watch the fill count. An almost-full level raises a receive service request, and an almost-empty level raises a transmit service request. A per-direction DMA enable routes each request either to a DMA request line or to a threshold status flag. All four outputs are registered. They are updated at the same clock edge that applies a push, a pop or a configuration write, so a DMA request is a level that drops as soon as its condition ends. While no transfer is running and the buffer is empty, all four outputs are held low.

Top module: `thr_fifo_dma`

## Requirements
- R1: Words leave the buffer in the order they were accepted. The read and write positions wrap modulo 32, so ordering holds across any number of passes through the storage.
- R2: With `rx_dir`=1 (receive), the engine push and the processor pop act, and `cpu_wr_en` and `eng_pop_en` are ignored. With `rx_dir`=0 (transmit), the processor push and the engine pop act, and `eng_push_en` and `cpu_rd_en` are ignored.
- R3: A push while the buffer holds 32 words is discarded. The count and the stored contents do not change.
- R4: A pop from an empty buffer presents the word at the current read position on the pop data output, and the count and the read position do not change.
- R5: The configuration word carries the receive DMA enable in bit 15, the almost-full level in bits 12:8, the transmit DMA enable in bit 7 and the almost-empty level in bits 4:0. Bits 14:13 and 6:5 read back as 0. After reset the word reads 16'h1F00 (almost-full 31, almost-empty 0, both DMA enables off).
- R6: In receive direction, a fill count strictly greater than the almost-full level asserts `rx_dma_req` if receive DMA is enabled and `rx_thr_flag` otherwise.
- R7: In transmit direction, a fill count strictly less than the almost-empty level asserts `tx_dma_req` if transmit DMA is enabled and `tx_thr_flag` otherwise.
- R8: With `xfer_active`=0 and an empty buffer, all four request and flag outputs are 0.
- R9: The outputs reflect the count and configuration that result from the operations of the previous clock edge. Enabling DMA for a direction clears that direction's flag at that same edge, and a DMA request drops at the edge where its condition ends.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| xfer_active | input | 1 | A data transfer is in progress |
| rx_dir | input | 1 | 1 = receive (engine fills), 0 = transmit (processor fills) |
| cpu_wr_en | input | 1 | Processor push strobe |
| cpu_wr_data | input | 16 | Processor push word |
| cpu_rd_en | input | 1 | Processor pop strobe |
| cpu_rd_data | output | 16 | Word at the read position |
| eng_push_en | input | 1 | Engine push strobe |
| eng_push_data | input | 16 | Engine push word |
| eng_pop_en | input | 1 | Engine pop strobe |
| eng_pop_data | output | 16 | Word at the read position |
| cfg_wr_en | input | 1 | Configuration write strobe |
| cfg_wr_data | input | 16 | Configuration word to write |
| cfg_rd_data | output | 16 | Current configuration word |
| rx_dma_req | output | 1 | Receive DMA request (level) |
| tx_dma_req | output | 1 | Transmit DMA request (level) |
| rx_thr_flag | output | 1 | Receive threshold flag |
| tx_thr_flag | output | 1 | Transmit threshold flag |

## Verification
The assertions assume that `rx_dir` and `xfer_active` come from registered control and change only between operations. They also assume that the buffer depth is a power of two, so that the free-running pointers wrap exactly at the depth. The stimulus changes direction and activity only when no strobe is pending. It deliberately toggles the strobes of the side that does not own an operation, which exercises the ignore rule, and it pushes into a full buffer and pops from an empty one only to exercise R3 and R4.

// File: rtl/thrfifo_pkg.sv
package thrfifo_pkg;
    localparam int unsigned DATA_W   = 16;
    localparam int unsigned DEPTH    = 32;
    localparam int unsigned PTR_W    = $clog2(DEPTH);
    localparam int unsigned CNT_W    = PTR_W + 1;
    localparam int unsigned CFG_W    = 16;
    localparam int unsigned RXEN_BIT = 15;
    localparam int unsigned AF_LSB   = 8;
    localparam int unsigned TXEN_BIT = 7;
    localparam int unsigned AE_LSB   = 0;

    typedef logic [DATA_W-1:0] word_t;
    typedef logic [PTR_W-1:0]  ptr_t;
    typedef logic [CNT_W-1:0]  cnt_t;
    typedef logic [CFG_W-1:0]  cfg_word_t;

    localparam cnt_t CNT_FULL = cnt_t'(DEPTH);

    typedef enum logic {
        DIR_TX = 1'b0,
        DIR_RX = 1'b1
    } xfer_dir_e;

    typedef struct packed {
        logic rx_dma_en;
        ptr_t af_lvl;
        logic tx_dma_en;
        ptr_t ae_lvl;
    } thr_cfg_t;

    localparam thr_cfg_t CFG_RESET = '{rx_dma_en: 1'b0, af_lvl: '1,
                                       tx_dma_en: 1'b0, ae_lvl: '0};

    typedef struct packed {
        logic req;
        logic flag;
    } svc_t;

    function automatic thr_cfg_t cfg_decode(cfg_word_t w);
        thr_cfg_t c;
        c.rx_dma_en = w[RXEN_BIT];
        c.af_lvl    = w[AF_LSB +: PTR_W];
        c.tx_dma_en = w[TXEN_BIT];
        c.ae_lvl    = w[AE_LSB +: PTR_W];
        return c;
    endfunction

    function automatic cfg_word_t cfg_encode(thr_cfg_t c);
        cfg_word_t w;
        w = '0;
        w[RXEN_BIT]          = c.rx_dma_en;
        w[AF_LSB +: PTR_W]   = c.af_lvl;
        w[TXEN_BIT]          = c.tx_dma_en;
        w[AE_LSB +: PTR_W]   = c.ae_lvl;
        return w;
    endfunction

    function automatic svc_t svc_route(logic hit, logic dma_en, logic idle);
        svc_t s;
        s.req  = !idle && hit && dma_en;
        s.flag = !idle && hit && !dma_en;
        return s;
    endfunction
endpackage

// File: rtl/thrfifo_store.sv
module thrfifo_store
    import thrfifo_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  push,
    input  word_t push_data,
    input  logic  pop,
    output word_t head,
    output cnt_t  count_q,
    output cnt_t  count_d
);
    word_t mem [DEPTH];
    ptr_t  wr_ptr;
    ptr_t  rd_ptr;
    logic  push_ok;
    logic  pop_ok;

    assign push_ok = push && (count_q != CNT_FULL);
    assign pop_ok  = pop && (count_q != '0);
    assign count_d = count_q + cnt_t'(push_ok) - cnt_t'(pop_ok);
    assign head    = mem[rd_ptr];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < int'(DEPTH); i++) mem[i] <= '0;
        end else if (push_ok) begin
            mem[wr_ptr] <= push_data;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_ptr  <= '0;
            rd_ptr  <= '0;
            count_q <= '0;
        end else begin
            if (push_ok) wr_ptr <= wr_ptr + ptr_t'(1);
            if (pop_ok)  rd_ptr <= rd_ptr + ptr_t'(1);
            count_q <= count_d;
        end
    end

    // R3: the count never exceeds the depth
    p_no_overflow_r3: assert property (@(posedge clk) disable iff (rst)
        count_q <= CNT_FULL);

    // R3: a push into a full buffer leaves count and write position unchanged
    p_full_push_r3: assert property (@(posedge clk) disable iff (rst)
        (count_q == CNT_FULL && push && !pop) |=> (count_q == CNT_FULL && $stable(wr_ptr)));

    // R4: a pop from an empty buffer leaves count and read position unchanged
    p_empty_pop_r4: assert property (@(posedge clk) disable iff (rst)
        (count_q == '0 && pop && !push) |=> (count_q == '0 && $stable(rd_ptr)));
endmodule

// File: rtl/thrfifo_cfg.sv
module thrfifo_cfg
    import thrfifo_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      wr_en,
    input  cfg_word_t wr_data,
    output thr_cfg_t  cfg_q,
    output thr_cfg_t  cfg_d,
    output cfg_word_t rd_data
);
    assign cfg_d   = wr_en ? cfg_decode(wr_data) : cfg_q;
    assign rd_data = cfg_encode(cfg_q);

    always_ff @(posedge clk) begin
        if (rst) cfg_q <= CFG_RESET;
        else     cfg_q <= cfg_d;
    end

    // R5: configuration holds between writes
    p_cfg_hold_r5: assert property (@(posedge clk) disable iff (rst)
        !wr_en |=> $stable(cfg_q));
endmodule

// File: rtl/thrfifo_level.sv
module thrfifo_level
    import thrfifo_pkg::*;
#(
    parameter bit IS_RX = 1'b0
) (
    input  logic      clk,
    input  logic      rst,
    input  cnt_t      cnt_d,
    input  thr_cfg_t  cfg_d,
    input  xfer_dir_e dir,
    input  logic      active,
    output logic      req_q,
    output logic      flag_q
);
    logic hit;
    logic dma_en;
    logic idle;
    svc_t svc_d;

    generate
        if (IS_RX) begin : g_rx
            assign hit    = (dir == DIR_RX) && (cnt_d > {1'b0, cfg_d.af_lvl});
            assign dma_en = cfg_d.rx_dma_en;
        end else begin : g_tx
            assign hit    = (dir == DIR_TX) && (cnt_d < {1'b0, cfg_d.ae_lvl});
            assign dma_en = cfg_d.tx_dma_en;
        end
    endgenerate

    assign idle  = !active && (cnt_d == '0);
    assign svc_d = svc_route(hit, dma_en, idle);

    always_ff @(posedge clk) begin
        if (rst) begin
            req_q  <= 1'b0;
            flag_q <= 1'b0;
        end else begin
            req_q  <= svc_d.req;
            flag_q <= svc_d.flag;
        end
    end

    // R9: a direction never shows both a DMA request and a flag
    p_req_flag_excl_r9: assert property (@(posedge clk) disable iff (rst)
        !(req_q && flag_q));

    // R9: with DMA enabled the flag is clear after the edge
    p_dma_clears_flag_r9: assert property (@(posedge clk) disable iff (rst)
        dma_en |=> !flag_q);

    // R8: idle and empty silences this direction
    p_idle_quiet_r8: assert property (@(posedge clk) disable iff (rst)
        idle |=> (!req_q && !flag_q));
endmodule

// File: rtl/thr_fifo_dma.sv
module thr_fifo_dma
    import thrfifo_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        xfer_active,
    input  logic        rx_dir,
    input  logic        cpu_wr_en,
    input  logic [15:0] cpu_wr_data,
    input  logic        cpu_rd_en,
    output logic [15:0] cpu_rd_data,
    input  logic        eng_push_en,
    input  logic [15:0] eng_push_data,
    input  logic        eng_pop_en,
    output logic [15:0] eng_pop_data,
    input  logic        cfg_wr_en,
    input  logic [15:0] cfg_wr_data,
    output logic [15:0] cfg_rd_data,
    output logic        rx_dma_req,
    output logic        tx_dma_req,
    output logic        rx_thr_flag,
    output logic        tx_thr_flag
);
    localparam int unsigned N_DIR = 2;

    xfer_dir_e  dir;
    logic       push;
    word_t      push_data;
    logic       pop;
    word_t      head;
    cnt_t       count_q;
    cnt_t       count_d;
    thr_cfg_t   cfg_q;
    thr_cfg_t   cfg_d;
    logic [N_DIR-1:0] req_v;
    logic [N_DIR-1:0] flag_v;

    assign dir       = rx_dir ? DIR_RX : DIR_TX;
    assign push      = (dir == DIR_RX) ? eng_push_en   : cpu_wr_en;
    assign push_data = (dir == DIR_RX) ? eng_push_data : cpu_wr_data;
    assign pop       = (dir == DIR_RX) ? cpu_rd_en     : eng_pop_en;

    thrfifo_store u_store (
        .clk       (clk),
        .rst       (rst),
        .push      (push),
        .push_data (push_data),
        .pop       (pop),
        .head      (head),
        .count_q   (count_q),
        .count_d   (count_d)
    );

    thrfifo_cfg u_cfg (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (cfg_wr_en),
        .wr_data (cfg_wr_data),
        .cfg_q   (cfg_q),
        .cfg_d   (cfg_d),
        .rd_data (cfg_rd_data)
    );

    // index 0 serves transmit, index 1 serves receive
    generate
        for (genvar g = 0; g < int'(N_DIR); g++) begin : g_lvl
            thrfifo_level #(.IS_RX(bit'(g))) u_lvl (
                .clk    (clk),
                .rst    (rst),
                .cnt_d  (count_d),
                .cfg_d  (cfg_d),
                .dir    (dir),
                .active (xfer_active),
                .req_q  (req_v[g]),
                .flag_q (flag_v[g])
            );
        end
    endgenerate

    assign cpu_rd_data  = head;
    assign eng_pop_data = head;
    assign tx_dma_req   = req_v[0];
    assign rx_dma_req   = req_v[1];
    assign tx_thr_flag  = flag_v[0];
    assign rx_thr_flag  = flag_v[1];

    // R2: only the direction in force may raise service
    p_one_dir_r2: assert property (@(posedge clk) disable iff (rst)
        !((rx_dma_req || rx_thr_flag) && (tx_dma_req || tx_thr_flag)));

    // R6: receive service needs more words than the almost-full level
    p_rx_level_r6: assert property (@(posedge clk) disable iff (rst)
        (rx_dma_req || rx_thr_flag) |-> (count_q > {1'b0, cfg_q.af_lvl}));

    // R7: transmit service needs fewer words than the almost-empty level
    p_tx_level_r7: assert property (@(posedge clk) disable iff (rst)
        (tx_dma_req || tx_thr_flag) |-> (count_q < {1'b0, cfg_q.ae_lvl}));
endmodule

// File: tb/sim_thr_fifo_dma.sv
`timescale 1ns/1ps
module sim_thr_fifo_dma;
    logic        clk = 1'b0;
    logic        rst;
    logic        xfer_active, rx_dir;
    logic        cpu_wr_en, cpu_rd_en, eng_push_en, eng_pop_en, cfg_wr_en;
    logic [15:0] cpu_wr_data, eng_push_data, cfg_wr_data;
    logic [15:0] cpu_rd_data, eng_pop_data, cfg_rd_data;
    logic        rx_dma_req, tx_dma_req, rx_thr_flag, tx_thr_flag;

    always #2.5 clk = ~clk;

    thr_fifo_dma u0 (
        .clk(clk), .rst(rst), .xfer_active(xfer_active), .rx_dir(rx_dir),
        .cpu_wr_en(cpu_wr_en), .cpu_wr_data(cpu_wr_data),
        .cpu_rd_en(cpu_rd_en), .cpu_rd_data(cpu_rd_data),
        .eng_push_en(eng_push_en), .eng_push_data(eng_push_data),
        .eng_pop_en(eng_pop_en), .eng_pop_data(eng_pop_data),
        .cfg_wr_en(cfg_wr_en), .cfg_wr_data(cfg_wr_data), .cfg_rd_data(cfg_rd_data),
        .rx_dma_req(rx_dma_req), .tx_dma_req(tx_dma_req),
        .rx_thr_flag(rx_thr_flag), .tx_thr_flag(tx_thr_flag)
    );

    int n_chk = 0;
    int n_fail = 0;
    logic [15:0] sb_q[$];
    logic [15:0] shadow [32];
    int sh_wr = 0, sh_rd = 0, m_cnt = 0;
    bit m_rxen = 0, m_txen = 0;
    int m_af = 31, m_ae = 0;

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [15:0] cfg_word();
        return {m_rxen, 2'b00, 5'(m_af), m_txen, 2'b00, 5'(m_ae)};
    endfunction

    task automatic set_mode(input bit dir, input bit act);
        @(negedge clk);
        rx_dir = dir;
        xfer_active = act;
    endtask

    // driver: applies one cycle of strobes, updates the scoreboard and model
    task automatic step(input bit cw, input logic [15:0] cwd, input bit cr,
                        input bit ep, input logic [15:0] epd, input bit eo,
                        input bit gw, input logic [15:0] gwd, input string tag);
        bit psh, pp, pok, ook;
        logic [15:0] pdata;
        bit idle, hr, ht;
        @(negedge clk);
        cpu_wr_en = cw; cpu_wr_data = cwd; cpu_rd_en = cr;
        eng_push_en = ep; eng_push_data = epd; eng_pop_en = eo;
        cfg_wr_en = gw; cfg_wr_data = gwd;
        #1;
        psh   = rx_dir ? ep : cw;
        pdata = rx_dir ? epd : cwd;
        pp    = rx_dir ? cr : eo;
        pok   = psh && (m_cnt < 32);
        ook   = pp && (m_cnt > 0);
        // monitor: compare the popped word against the scoreboard
        if (ook) check("R1 pop order", rx_dir ? cpu_rd_data : eng_pop_data, sb_q[0]);
        else if (pp) check("R4 empty pop head", rx_dir ? cpu_rd_data : eng_pop_data, shadow[sh_rd]);
        @(posedge clk);
        #1;
        cpu_wr_en = 0; cpu_rd_en = 0; eng_push_en = 0; eng_pop_en = 0; cfg_wr_en = 0;
        if (ook) begin
            void'(sb_q.pop_front());
            sh_rd = (sh_rd + 1) % 32;
        end
        if (pok) begin
            sb_q.push_back(pdata);
            shadow[sh_wr] = pdata;
            sh_wr = (sh_wr + 1) % 32;
        end
        m_cnt = m_cnt + int'(pok) - int'(ook);
        if (gw) begin
            m_rxen = gwd[15]; m_af = int'(gwd[12:8]);
            m_txen = gwd[7];  m_ae = int'(gwd[4:0]);
        end
        idle = !xfer_active && (m_cnt == 0);
        hr   = rx_dir && (m_cnt > m_af);
        ht   = !rx_dir && (m_cnt < m_ae);
        check({tag, " rx_dma_req"},  rx_dma_req,  !idle && hr && m_rxen);
        check({tag, " rx_thr_flag"}, rx_thr_flag, !idle && hr && !m_rxen);
        check({tag, " tx_dma_req"},  tx_dma_req,  !idle && ht && m_txen);
        check({tag, " tx_thr_flag"}, tx_thr_flag, !idle && ht && !m_txen);
    endtask

    task automatic cpu_push(input logic [15:0] d, input string tag);
        step(1, d, 0, 0, 16'h0, 0, 0, 16'h0, tag);
    endtask
    task automatic eng_push(input logic [15:0] d, input string tag);
        step(0, 16'h0, 0, 1, d, 0, 0, 16'h0, tag);
    endtask
    task automatic cfg_write(input logic [15:0] d, input string tag);
        step(0, 16'h0, 0, 0, 16'h0, 0, 1, d, tag);
    endtask

    initial begin
        for (int i = 0; i < 32; i++) shadow[i] = 16'h0;
        rst = 1; xfer_active = 0; rx_dir = 0;
        cpu_wr_en = 0; cpu_rd_en = 0; eng_push_en = 0; eng_pop_en = 0; cfg_wr_en = 0;
        cpu_wr_data = 0; eng_push_data = 0; cfg_wr_data = 0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 0;
        #1;
        check("R5 reset cfg", cfg_rd_data, 16'h1F00);
        check("R8 reset outputs", {rx_dma_req, tx_dma_req, rx_thr_flag, tx_thr_flag}, 4'b0);
        check("R4 reset head", cpu_rd_data, 16'h0);

        // transmit direction, almost-empty level 4, no DMA
        set_mode(0, 1);
        cfg_write(16'h1F04, "R7 below level flag");
        check("R5 cfg readback", cfg_rd_data, 16'h1F04);
        cpu_push(16'hA001, "R7");
        cpu_push(16'hA002, "R7");
        cpu_push(16'hA003, "R7");
        cpu_push(16'hA004, "R7 at level");
        step(0, 16'h0, 1, 1, 16'hBAD0, 0, 0, 16'h0, "R2 wrong side ignored");
        step(0, 16'h0, 0, 0, 16'h0, 1, 0, 16'h0, "R7 pop below level");
        cfg_write(16'h1F84, "R9 dma enable clears flag");
        cpu_push(16'hA005, "R9 request drops");
        for (int i = 0; i < 28; i++) cpu_push(16'hA100 + 16'(i), "R7 fill");
        cpu_push(16'hDEAD, "R3 full push discarded");
        check("R3 count at full", m_cnt, 32);
        for (int i = 0; i < 32; i++) step(0, 16'h0, 0, 0, 16'h0, 1, 0, 16'h0, "R1 drain");
        step(0, 16'h0, 0, 0, 16'h0, 1, 0, 16'h0, "R4 empty pop");
        set_mode(0, 0);
        step(0, 16'h0, 0, 0, 16'h0, 0, 0, 16'h0, "R8 idle empty");
        set_mode(0, 1);
        step(0, 16'h0, 0, 0, 16'h0, 0, 0, 16'h0, "R7 active again");

        // receive direction, almost-full level 2, no DMA
        set_mode(1, 1);
        cfg_write(16'h0200, "R6 config");
        eng_push(16'hC001, "R6");
        eng_push(16'hC002, "R6");
        step(1, 16'hBAD1, 0, 0, 16'h0, 1, 0, 16'h0, "R2 wrong side ignored rx");
        eng_push(16'hC003, "R6 above level flag");
        cfg_write(16'h8200, "R9 dma enable clears rx flag");
        step(0, 16'h0, 1, 0, 16'h0, 0, 0, 16'h0, "R9 rx request drops");
        cfg_write(16'hFFFF, "R5 masked write");
        check("R5 unused bits read zero", cfg_rd_data, 16'h9F9F);
        cfg_write(16'h8300, "R6 level 3");

        // streaming push and pop together across several wraps
        for (int i = 0; i < 80; i++)
            step(0, 16'h0, 1, 1, 16'hE000 + 16'(i), 0, 0, 16'h0, "R1 wrap stream");
        for (int i = 0; i < 6; i++) eng_push(16'hF000 + 16'(i), "R6 refill");
        set_mode(1, 0);
        while (m_cnt > 0) step(0, 16'h0, 1, 0, 16'h0, 0, 0, 16'h0, "R1 final drain");
        step(0, 16'h0, 0, 0, 16'h0, 0, 0, 16'h0, "R8 final idle");

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        #(200000 * 5);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog expired");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule